// File: doc/BRIEF.md
# Cascaded Harmonic Square-Wave Divider

This block turns one fast stream of input edges into a family of slower square waves. Their frequencies are integer fractions of the input rate, and together they form a harmonic set for additive synthesis. The input edges arrive as a one-cycle enable on the system clock. A chain of divide-by-factor stages counts those edges. Each stage counts the division strobes of the stage before it, so a few small counters reach a large overall ratio.

Every tap is driven by a toggle stage fed from one node of the chain, so each tap is an exact 50% square wave. This includes the nodes that come out of odd-factor counters. With the default factors 3, 5 and 7, and input edges at a nominal 1680 per unit time, the taps run at 840, 280, 56 and 8. The real input rate is free, and every tap scales with it.

The division order is a parameter. For example, 7, 5 and 3 lowers the intermediate node rates but reaches the same lowest tap.

Top module: `harmonic_divtree`

## Requirements
- R1: While `rst` is high at a clock edge, every tap goes low and every stage count returns to zero. The first enabled edge after reset starts the counting from zero.
- R2: Tap 0 inverts once for every clock cycle in which `edge_en` is high, so its rate is half the input edge rate.
- R3: Stage k counts the strobes of node k. Node 0 is `edge_en`. Stage k emits exactly one strobe on node k+1 for every `FACTORS[k]` strobes of node k, and that strobe falls in the same cycle as the strobe that completes the count.
- R4: Tap k inverts once per strobe of node k. After E enabled input edges from reset, tap k equals bit 0 of E divided (rounding down) by the product of the first k factors.
- R5: Over any run whose length is a multiple of its period, every tap is high for exactly half of the enabled input edges.
- R6: A cycle with `edge_en` low changes no tap and no stage count.
- R7: Taps are registered. A tap changes one clock edge after the cycle whose `edge_en` caused it, and never earlier.
- R8: The factor order is a parameter. With 3,5,7 the taps divide the input by 2, 6, 30 and 210. With 7,5,3 they divide by 2, 14, 70 and 210.
- R9: Each tap is bit `k` of the `tap` port: bit 0 is the fastest and bit `NSTG` the slowest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| edge_en | input | 1 | One-cycle marker of each input edge |
| tap | output | NSTG+1 | Registered square-wave outputs, bit 0 fastest |

## Verification
The bench builds two copies side by side. One uses the default order 3, 5, 7. The other uses the reversed order 7, 5, 3. Both copies share the same edge stream, so two different sets of intermediate ratios are checked against one product of 105. Runs of 840 edges cover whole periods of every tap in both copies, which brings the transition counts and the half-period high counts within reach. Gapped edge patterns and a reset taken in mid-count show that the counts hold across idle cycles and restart cleanly.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;
  // Counter width needed to hold 0 .. n-1 (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Ratio of input edges to one full period of tap k, given the prefix product.
  function automatic int unsigned tap_period(input int unsigned prefix_prod);
    return 2 * prefix_prod;
  endfunction
endpackage

// File: rtl/hdiv_stage.sv
module hdiv_stage #(
  parameter int unsigned N = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic src_stb,
  output logic out_stb
);
  localparam int unsigned W = hdiv_pkg::cnt_width(N);
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] cnt;
  logic         wrap;

  assign wrap    = (cnt == LAST);
  assign out_stb = src_stb && wrap;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (src_stb) cnt <= wrap ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/hdiv_half.sv
module hdiv_half (
  input  logic clk,
  input  logic rst,
  input  logic src_stb,
  output logic sq
);
  always_ff @(posedge clk) begin
    if (rst)          sq <= 1'b0;
    else if (src_stb) sq <= ~sq;
  end
endmodule

// File: rtl/harmonic_divtree.sv
module harmonic_divtree #(
  parameter int unsigned NSTG = 3,
  parameter int unsigned FACTORS [NSTG] = '{3, 5, 7}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          edge_en,
  output logic [NSTG:0] tap
);
  localparam int unsigned NTAP = NSTG + 1;

  // node_stb[0] is the input edge; node_stb[k+1] is the output of stage k.
  logic [NSTG:0] node_stb;
  assign node_stb[0] = edge_en;

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    hdiv_stage #(.N(FACTORS[k])) u_stage (
      .clk     (clk),
      .rst     (rst),
      .src_stb (node_stb[k]),
      .out_stb (node_stb[k+1])
    );
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    hdiv_half u_half (
      .clk     (clk),
      .rst     (rst),
      .src_stb (node_stb[k]),
      .sq      (tap[k])
    );
  end
endmodule

// File: rtl/hdiv_checker.sv
module hdiv_checker #(
  parameter int unsigned NSTG = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [NSTG:0] node_stb,
  input logic [NSTG:0] tap
);
  // R1: reset clears every tap on the next edge
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (tap == '0));

  for (genvar k = 0; k <= NSTG; k++) begin : g_tapchk
    // R6: no strobe on the source node, tap holds
    p_tap_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !node_stb[k] |=> (tap[k] == $past(tap[k])));
    // R4: a strobe on the source node flips the tap one edge later (R7)
    p_tap_flip_r4: assert property (@(posedge clk) disable iff (rst)
      node_stb[k] |=> (tap[k] != $past(tap[k])));
  end

  for (genvar k = 1; k <= NSTG; k++) begin : g_spacing
    // R3: a stage of factor two or more never strobes in consecutive cycles
    p_stage_spacing_r3: assert property (@(posedge clk) disable iff (rst)
      node_stb[k] |=> !node_stb[k]);
  end
endmodule

bind harmonic_divtree hdiv_checker #(.NSTG(NSTG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .node_stb (node_stb),
  .tap      (tap)
);

// File: tb/sim_harmonic_divtree.sv
module sim_harmonic_divtree;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic edge_en = 1'b0;
  logic [3:0] tap_a, tap_b;

  int n_checks = 0;
  int n_fail = 0;
  int edges = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [3:0] exp_a;
    logic [3:0] exp_b;
    bit         is_edge;
  } item_t;
  item_t sbq[$];

  int rises_a [4];
  int highs_a [4];
  int rises_b [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  harmonic_divtree u0 (.clk(clk), .rst(rst), .edge_en(edge_en), .tap(tap_a));
  harmonic_divtree #(.NSTG(3), .FACTORS('{7, 5, 3})) u1 (
    .clk(clk), .rst(rst), .edge_en(edge_en), .tap(tap_b));

  // Expected taps after e edges: bit k is the parity of e / (f0*..*f(k-1)).
  function automatic logic [3:0] model(input int e, input int f0, input int f1, input int f2);
    int div [4];
    logic [3:0] r;
    div[0] = 1; div[1] = f0; div[2] = f0 * f1; div[3] = f0 * f1 * f2;
    for (int k = 0; k < 4; k++) r[k] = ((e / div[k]) % 2) == 1;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one call per cycle; pushes the state expected after that edge.
  task automatic drive(input bit en);
    item_t it;
    @(negedge clk);
    edge_en = en;
    if (en) edges++;
    it.exp_a = model(edges, 3, 5, 7);
    it.exp_b = model(edges, 7, 5, 3);
    it.is_edge = en;
    sbq.push_back(it);
  endtask

  task automatic stop_drive();
    @(negedge clk);
    edge_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    edge_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    edges = 0;
    for (int k = 0; k < 4; k++) begin
      rises_a[k] = 0; highs_a[k] = 0; rises_b[k] = 0;
    end
    check("R1 taps low after reset u0", 32'(tap_a), 32'h0);
    check("R1 taps low after reset u1", 32'(tap_b), 32'h0);
  endtask

  // Monitor: pops one expectation after every clock edge.
  initial begin
    logic [3:0] prev_a, prev_b;
    item_t it;
    prev_a = '0; prev_b = '0;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        check("R2 R3 R4 R8 R9 scoreboard u0", 32'(tap_a), 32'(it.exp_a));
        check("R3 R4 R8 scoreboard u1", 32'(tap_b), 32'(it.exp_b));
        for (int k = 0; k < 4; k++) begin
          if (tap_a[k] && !prev_a[k]) rises_a[k]++;
          if (tap_b[k] && !prev_b[k]) rises_b[k]++;
          if (it.is_edge && tap_a[k]) highs_a[k]++;
        end
      end
      prev_a = tap_a;
      prev_b = tap_b;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] snap_a, snap_b;
    repeat (3) @(posedge clk);
    do_reset();

    // R7: the first edge must not show before the clock edge, and shows after it
    @(negedge clk);
    edge_en = 1'b1;
    #1;
    check("R7 tap0 unchanged before edge", 32'(tap_a[0]), 32'h0);
    @(posedge clk);
    #1;
    edge_en = 1'b0;
    check("R7 tap0 set one edge later", 32'(tap_a[0]), 32'h1);
    do_reset();

    // Continuous run of whole periods: ratios and duty
    for (int i = 0; i < 840; i++) drive(1'b1);
    stop_drive();
    check("R2 tap0 rises u0", 32'(rises_a[0]), 32'd420);
    check("R4 tap1 rises u0", 32'(rises_a[1]), 32'd140);
    check("R4 tap2 rises u0", 32'(rises_a[2]), 32'd28);
    check("R4 tap3 rises u0", 32'(rises_a[3]), 32'd4);
    check("R8 tap1 rises u1", 32'(rises_b[1]), 32'd60);
    check("R8 tap2 rises u1", 32'(rises_b[2]), 32'd12);
    check("R8 tap3 rises u1", 32'(rises_b[3]), 32'd4);
    for (int k = 0; k < 4; k++)
      check("R5 half-high duty u0", 32'(highs_a[k]), 32'd420);

    // Gapped edges: idle cycles must change nothing
    for (int i = 0; i < 600; i++) drive((i % 3) != 1);
    stop_drive();

    snap_a = tap_a;
    snap_b = tap_b;
    repeat (20) @(negedge clk);
    check("R6 idle hold u0", 32'(tap_a), 32'(snap_a));
    check("R6 idle hold u1", 32'(tap_b), 32'(snap_b));

    // Reset in mid-count, then restart from zero
    for (int i = 0; i < 47; i++) drive(1'b1);
    stop_drive();
    do_reset();
    for (int i = 0; i < 250; i++) drive((i % 5) != 0);
    stop_drive();
    check("R1 restart edge count", 32'(tap_a), 32'(model(edges, 3, 5, 7)));

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule